// File: doc/BRIEF.md
# Private L2 Line Coherence Controller

This block holds the MESI coherence state for a small set of lines in a private second-level cache. On one side is the first-level cache of the same tile, and on the other is a directory-based last-level cache reached over a message network. Read and write requests arrive from the L1 side. Data, Invalidate, InvAck and forwarded GetM messages arrive from the network. Each accepted request or message updates the state of exactly one line and may produce one outgoing network message (GetS, GetM, InvAck or Data) and a pulse that invalidates the L1 copy.

The controller handles the Shared-to-Modified upgrade race. An Invalidate can arrive while the upgrade is pending. When that happens, the line falls back to the invalidated-and-waiting path, acknowledges the invalidating writer and removes the stale L1 copy. A forwarded GetM that arrives before the line owns its data is parked, one per line, and is served once every acknowledgement has been counted. Data storage, replacement, the directory and packetization are outside the block. Each channel is a single-cycle valid/ready transfer carrying a type, a line index and a node ID. The controller performs one action per cycle.

Top module: `coh_line_ctrl`

## Requirements
- R1: A write from L1 to a Shared line sends GetM to the directory ID and moves the line to SMAD. While a line is in any transient state, L1 requests to that line see ready low.
- R2: Data in SMAD moves the line to SMA when the count still owed is nonzero. When the count owed is zero, the line goes directly to Modified.
- R3: An Invalidate in SMAD sends InvAck to the node named in the Invalidate and moves the line to IMAD.
- R4: Every accepted Invalidate that removes the L2 copy (in Shared or SMAD) also pulses l1_inv_valid_o with that line's index.
- R5: A forwarded GetM arriving in IMAD, SMAD, IMA or SMA produces no output and is parked together with its requester ID.
- R6: An InvAck that brings the owed count to zero in IMA or SMA moves the line to Modified. In the following free cycle, the parked forwarded GetM is served.
- R7: A forwarded GetM served in Modified, whether direct or parked, sends Data to the requester, pulses the L1 invalidate and leaves the line Invalid.
- R8: Data in IMAD moves the line to Modified when the owed count is zero and to IMA otherwise.
- R9: The owed count is signed. An InvAck taken in IMAD or SMAD before the Data lowers it, and the Data adds its carried count to it.
- R10: A forwarded GetM to a line that already has one parked sees net_in_ready_o low, and the parked requester is kept.
- R11: A network message that is illegal in the line's state is consumed, pulses err_o one cycle later and leaves the state unchanged.
- R12: Reset leaves every line Invalid, with nothing parked, all counts zero and every output low.
- R13: A read in Invalid sends GetS and waits in ISD, and Data then makes the line Shared. A read in Shared or Modified, or a write in Modified, pulses l1_hit_o.
- R14: Actions are served in priority order: parked-request service first, then the network, then L1. An action is taken only when the output register is empty or draining. Outputs appear one cycle after acceptance, and a stalled output holds its contents. Inbound type codes are 0 Data, 1 Invalidate, 2 InvAck, 3 forwarded GetM. Outbound type codes are 0 GetS, 1 GetM, 2 InvAck, 3 Data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l1_req_valid_i | input | 1 | L1 request valid |
| l1_req_ready_o | output | 1 | L1 request accepted |
| l1_req_write_i | input | 1 | 1 for a write, 0 for a read |
| l1_req_addr_i | input | IDX_W | Line index of the L1 request |
| net_in_valid_i | input | 1 | Inbound message valid |
| net_in_ready_o | output | 1 | Inbound message accepted |
| net_in_type_i | input | 2 | Inbound message type |
| net_in_addr_i | input | IDX_W | Inbound line index |
| net_in_src_i | input | ID_W | Requester ID carried by the message |
| net_in_acks_i | input | ACK_W | Acknowledgement count carried by Data |
| net_out_valid_o | output | 1 | Outbound message valid |
| net_out_ready_i | input | 1 | Outbound message taken |
| net_out_type_o | output | 2 | Outbound message type |
| net_out_addr_o | output | IDX_W | Outbound line index |
| net_out_dst_o | output | ID_W | Destination node ID |
| l1_inv_valid_o | output | 1 | One-cycle L1 invalidate pulse |
| l1_inv_addr_o | output | IDX_W | Line index to invalidate in L1 |
| l1_hit_o | output | 1 | One-cycle pulse for an L1 access that hits |
| err_o | output | 1 | One-cycle pulse for an illegal message |

## Verification
The upgrade is driven along four paths. In the first, Data carries a nonzero count and forwarded GetMs arrive while acknowledgements are still owed. In the second, an Invalidate arrives in SMAD before the Data, and only this path distinguishes a missing L1 invalidate or a wrong InvAck destination. In the third, an acknowledgement arrives ahead of the Data, which exposes an unsigned or saturating count. In the fourth, Data carries a zero count, which separates the direct entry to Modified from the waiting path. Illegal messages are each followed by a legal one whose response depends on the old state. A stalled output channel, and network and L1 requests arriving in the same cycle, exercise the arbitration. A behavioural model compares every output and ready signal on every cycle.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [2:0] {
    ST_I    = 3'd0,
    ST_S    = 3'd1,
    ST_M    = 3'd2,
    ST_ISD  = 3'd3,
    ST_IMAD = 3'd4,
    ST_SMAD = 3'd5,
    ST_IMA  = 3'd6,
    ST_SMA  = 3'd7
  } line_st_e;

  typedef enum logic [1:0] {
    NI_DATA    = 2'd0,
    NI_INV     = 2'd1,
    NI_INVACK  = 2'd2,
    NI_FWDGETM = 2'd3
  } net_in_e;

  typedef enum logic [1:0] {
    NO_GETS   = 2'd0,
    NO_GETM   = 2'd1,
    NO_INVACK = 2'd2,
    NO_DATA   = 2'd3
  } net_out_e;

  // waiting on data and/or acks
  function automatic logic is_pending(line_st_e s);
    return (s == ST_IMAD) || (s == ST_SMAD) || (s == ST_IMA) || (s == ST_SMA);
  endfunction

  function automatic logic is_stable(line_st_e s);
    return (s == ST_I) || (s == ST_S) || (s == ST_M);
  endfunction

endpackage

// File: rtl/coh_line_slot.sv
module coh_line_slot
  import coh_pkg::*;
#(
  parameter int ID_W  = 3,
  parameter int CNT_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    upd_i,
  input  line_st_e                st_d_i,
  input  logic signed [CNT_W-1:0] cnt_d_i,
  input  logic                    held_d_i,
  input  logic [ID_W-1:0]         hsrc_d_i,
  output line_st_e                st_o,
  output logic signed [CNT_W-1:0] cnt_o,
  output logic                    held_o,
  output logic [ID_W-1:0]         hsrc_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_o   <= ST_I;
      cnt_o  <= '0;
      held_o <= 1'b0;
      hsrc_o <= '0;
    end else if (upd_i) begin
      st_o   <= st_d_i;
      cnt_o  <= cnt_d_i;
      held_o <= held_d_i;
      hsrc_o <= hsrc_d_i;
    end
  end

  assert_held_state_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_o |-> !((st_o == ST_I) || (st_o == ST_S) || (st_o == ST_ISD)));

  assert_cnt_pos_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_o == ST_IMA) || (st_o == ST_SMA)) |-> (cnt_o > 0));

  assert_hsrc_kept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_o |=> (!held_o || $stable(hsrc_o)));

endmodule

// File: rtl/coh_drain_pick.sv
module coh_drain_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o
);

  // lowest index wins
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/coh_step.sv
module coh_step
  import coh_pkg::*;
#(
  parameter int              ID_W   = 3,
  parameter int              ACK_W  = 3,
  parameter int              CNT_W  = 4,
  parameter logic [ID_W-1:0] DIR_ID = '0
) (
  input  logic                    do_drain_i,
  input  logic                    do_net_i,
  input  logic                    do_l1_i,
  input  net_in_e                 mtype_i,
  input  logic [ID_W-1:0]         msrc_i,
  input  logic [ACK_W-1:0]        macks_i,
  input  logic                    l1_write_i,
  input  line_st_e                st_i,
  input  logic signed [CNT_W-1:0] cnt_i,
  input  logic                    held_i,
  input  logic [ID_W-1:0]         hsrc_i,
  output line_st_e                st_o,
  output logic signed [CNT_W-1:0] cnt_o,
  output logic                    held_o,
  output logic [ID_W-1:0]         hsrc_o,
  output logic                    emit_o,
  output net_out_e                otype_o,
  output logic [ID_W-1:0]         odst_o,
  output logic                    inv_o,
  output logic                    hit_o,
  output logic                    err_o
);

  logic signed [CNT_W-1:0] sum, dec;
  assign sum = cnt_i + $signed({{(CNT_W-ACK_W){1'b0}}, macks_i});
  assign dec = cnt_i - CNT_W'(1);

  always_comb begin
    st_o    = st_i;
    cnt_o   = cnt_i;
    held_o  = held_i;
    hsrc_o  = hsrc_i;
    emit_o  = 1'b0;
    otype_o = NO_GETS;
    odst_o  = DIR_ID;
    inv_o   = 1'b0;
    hit_o   = 1'b0;
    err_o   = 1'b0;
    if (do_drain_i) begin
      emit_o  = 1'b1;
      otype_o = NO_DATA;
      odst_o  = hsrc_i;
      inv_o   = 1'b1;
      st_o    = ST_I;
      held_o  = 1'b0;
    end else if (do_net_i) begin
      unique case (mtype_i)
        NI_DATA: begin
          if (st_i == ST_ISD) begin
            st_o = ST_S;
          end else if ((st_i == ST_IMAD) || (st_i == ST_SMAD)) begin
            if (sum == 0) begin
              st_o  = ST_M;
              cnt_o = '0;
            end else begin
              st_o  = (st_i == ST_IMAD) ? ST_IMA : ST_SMA;
              cnt_o = sum;
            end
          end else begin
            err_o = 1'b1;
          end
        end
        NI_INV: begin
          if ((st_i == ST_S) || (st_i == ST_SMAD)) begin
            st_o    = (st_i == ST_S) ? ST_I : ST_IMAD;
            emit_o  = 1'b1;
            otype_o = NO_INVACK;
            odst_o  = msrc_i;
            inv_o   = 1'b1;
          end else begin
            err_o = 1'b1;
          end
        end
        NI_INVACK: begin
          if (is_pending(st_i)) begin
            cnt_o = dec;
            if (((st_i == ST_IMA) || (st_i == ST_SMA)) && (dec == 0)) st_o = ST_M;
          end else begin
            err_o = 1'b1;
          end
        end
        NI_FWDGETM: begin
          if (st_i == ST_M) begin
            emit_o  = 1'b1;
            otype_o = NO_DATA;
            odst_o  = msrc_i;
            inv_o   = 1'b1;
            st_o    = ST_I;
          end else if (is_pending(st_i)) begin
            held_o = 1'b1;
            hsrc_o = msrc_i;
          end else begin
            err_o = 1'b1;
          end
        end
        default: err_o = 1'b1;
      endcase
    end else if (do_l1_i) begin
      unique case (st_i)
        ST_I: begin
          emit_o  = 1'b1;
          otype_o = l1_write_i ? NO_GETM : NO_GETS;
          st_o    = l1_write_i ? ST_IMAD : ST_ISD;
        end
        ST_S: begin
          if (l1_write_i) begin
            emit_o  = 1'b1;
            otype_o = NO_GETM;
            st_o    = ST_SMAD;
          end else begin
            hit_o = 1'b1;
          end
        end
        ST_M:    hit_o = 1'b1;
        default: err_o = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/coh_msg_out.sv
module coh_msg_out
  import coh_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int ID_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  net_out_e         type_i,
  input  logic [IDX_W-1:0] addr_i,
  input  logic [ID_W-1:0]  dst_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [1:0]       type_o,
  output logic [IDX_W-1:0] addr_o,
  output logic [ID_W-1:0]  dst_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      type_o  <= '0;
      addr_o  <= '0;
      dst_o   <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      type_o  <= type_i;
      addr_o  <= addr_i;
      dst_o   <= dst_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_out_hold_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(type_o) && $stable(addr_o) && $stable(dst_o)));

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int              NUM_LINES = 4,
  parameter int              ID_W      = 3,
  parameter int              ACK_W     = 3,
  parameter logic [ID_W-1:0] DIR_ID    = '0,
  localparam int             IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int             CNT_W     = ACK_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             l1_req_valid_i,
  output logic             l1_req_ready_o,
  input  logic             l1_req_write_i,
  input  logic [IDX_W-1:0] l1_req_addr_i,
  input  logic             net_in_valid_i,
  output logic             net_in_ready_o,
  input  logic [1:0]       net_in_type_i,
  input  logic [IDX_W-1:0] net_in_addr_i,
  input  logic [ID_W-1:0]  net_in_src_i,
  input  logic [ACK_W-1:0] net_in_acks_i,
  output logic             net_out_valid_o,
  input  logic             net_out_ready_i,
  output logic [1:0]       net_out_type_o,
  output logic [IDX_W-1:0] net_out_addr_o,
  output logic [ID_W-1:0]  net_out_dst_o,
  output logic             l1_inv_valid_o,
  output logic [IDX_W-1:0] l1_inv_addr_o,
  output logic             l1_hit_o,
  output logic             err_o
);

  line_st_e                st_q   [NUM_LINES];
  logic signed [CNT_W-1:0] cnt_q  [NUM_LINES];
  logic [ID_W-1:0]         hsrc_q [NUM_LINES];
  logic [NUM_LINES-1:0]    held_q;
  logic [NUM_LINES-1:0]    drain_req;

  net_in_e mtype;
  assign mtype = net_in_e'(net_in_type_i);

  logic             drain_vld, slot_free, drain_go, net_go, l1_go, any_go;
  logic [IDX_W-1:0] drain_idx, sel_idx;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_req
    assign drain_req[g] = held_q[g] && (st_q[g] == ST_M);
  end

  coh_drain_pick #(.N(NUM_LINES), .IDX_W(IDX_W)) u_pick (
    .req_i (drain_req),
    .vld_o (drain_vld),
    .idx_o (drain_idx)
  );

  assign slot_free      = !net_out_valid_o || net_out_ready_i;
  assign net_in_ready_o = slot_free && !drain_vld &&
                          !((mtype == NI_FWDGETM) && held_q[net_in_addr_i]);
  assign l1_req_ready_o = slot_free && !drain_vld && !net_in_valid_i &&
                          is_stable(st_q[l1_req_addr_i]);

  assign drain_go = drain_vld && slot_free;
  assign net_go   = net_in_valid_i && net_in_ready_o;
  assign l1_go    = l1_req_valid_i && l1_req_ready_o;
  assign any_go   = drain_go || net_go || l1_go;
  assign sel_idx  = drain_go ? drain_idx : (net_go ? net_in_addr_i : l1_req_addr_i);

  line_st_e                st_d;
  logic signed [CNT_W-1:0] cnt_d;
  logic                    held_d;
  logic [ID_W-1:0]         hsrc_d;
  logic                    emit_c, inv_c, hit_c, err_c;
  net_out_e                otype_c;
  logic [ID_W-1:0]         odst_c;

  coh_step #(.ID_W(ID_W), .ACK_W(ACK_W), .CNT_W(CNT_W), .DIR_ID(DIR_ID)) u_step (
    .do_drain_i (drain_go),
    .do_net_i   (net_go),
    .do_l1_i    (l1_go),
    .mtype_i    (mtype),
    .msrc_i     (net_in_src_i),
    .macks_i    (net_in_acks_i),
    .l1_write_i (l1_req_write_i),
    .st_i       (st_q[sel_idx]),
    .cnt_i      (cnt_q[sel_idx]),
    .held_i     (held_q[sel_idx]),
    .hsrc_i     (hsrc_q[sel_idx]),
    .st_o       (st_d),
    .cnt_o      (cnt_d),
    .held_o     (held_d),
    .hsrc_o     (hsrc_d),
    .emit_o     (emit_c),
    .otype_o    (otype_c),
    .odst_o     (odst_c),
    .inv_o      (inv_c),
    .hit_o      (hit_c),
    .err_o      (err_c)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    coh_line_slot #(.ID_W(ID_W), .CNT_W(CNT_W)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .upd_i    (any_go && (sel_idx == IDX_W'(g))),
      .st_d_i   (st_d),
      .cnt_d_i  (cnt_d),
      .held_d_i (held_d),
      .hsrc_d_i (hsrc_d),
      .st_o     (st_q[g]),
      .cnt_o    (cnt_q[g]),
      .held_o   (held_q[g]),
      .hsrc_o   (hsrc_q[g])
    );

    assert_illegal_keep_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (net_go && (net_in_addr_i == IDX_W'(g)) && (mtype == NI_INVACK) && !is_pending(st_q[g]))
      |=> (err_o && $stable(st_q[g])));

    assert_drain_serve_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (drain_req[g] && slot_free && (drain_idx == IDX_W'(g)))
      |=> ((st_q[g] == ST_I) && l1_inv_valid_o && (net_out_type_o == 2'(NO_DATA))));
  end

  coh_msg_out #(.IDX_W(IDX_W), .ID_W(ID_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (any_go && emit_c),
    .type_i  (otype_c),
    .addr_i  (sel_idx),
    .dst_i   (odst_c),
    .ready_i (net_out_ready_i),
    .valid_o (net_out_valid_o),
    .type_o  (net_out_type_o),
    .addr_o  (net_out_addr_o),
    .dst_o   (net_out_dst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l1_inv_valid_o <= 1'b0;
      l1_inv_addr_o  <= '0;
      l1_hit_o       <= 1'b0;
      err_o          <= 1'b0;
    end else begin
      l1_inv_valid_o <= any_go && inv_c;
      if (any_go && inv_c) l1_inv_addr_o <= sel_idx;
      l1_hit_o       <= any_go && hit_c;
      err_o          <= any_go && err_c;
    end
  end

  assert_smad_inv_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (net_go && (mtype == NI_INV) && (st_q[net_in_addr_i] == ST_SMAD))
    |=> (l1_inv_valid_o && net_out_valid_o && (net_out_type_o == 2'(NO_INVACK))));

endmodule

// File: tb/coh_line_ctrl_bench.sv
`timescale 1ns/100ps
module coh_line_ctrl_bench;

  localparam int NL = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       l1_req_valid = 1'b0, l1_req_write = 1'b0;
  logic [1:0] l1_req_addr = '0;
  logic       l1_req_ready;
  logic       net_in_valid = 1'b0;
  logic [1:0] net_in_type = '0, net_in_addr = '0;
  logic [2:0] net_in_src = '0, net_in_acks = '0;
  logic       net_in_ready;
  logic       net_out_valid, net_out_ready = 1'b1;
  logic [1:0] net_out_type, net_out_addr;
  logic [2:0] net_out_dst;
  logic       l1_inv_valid;
  logic [1:0] l1_inv_addr;
  logic       l1_hit, err;

  always #2.5 clk = ~clk;

  coh_line_ctrl u_coh_line_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .l1_req_valid_i(l1_req_valid), .l1_req_ready_o(l1_req_ready),
    .l1_req_write_i(l1_req_write), .l1_req_addr_i(l1_req_addr),
    .net_in_valid_i(net_in_valid), .net_in_ready_o(net_in_ready),
    .net_in_type_i(net_in_type), .net_in_addr_i(net_in_addr),
    .net_in_src_i(net_in_src), .net_in_acks_i(net_in_acks),
    .net_out_valid_o(net_out_valid), .net_out_ready_i(net_out_ready),
    .net_out_type_o(net_out_type), .net_out_addr_o(net_out_addr),
    .net_out_dst_o(net_out_dst),
    .l1_inv_valid_o(l1_inv_valid), .l1_inv_addr_o(l1_inv_addr),
    .l1_hit_o(l1_hit), .err_o(err)
  );

  // state codes of the model
  localparam int S_I = 0, S_S = 1, S_M = 2, S_ISD = 3, S_IMAD = 4, S_SMAD = 5, S_IMA = 6, S_SMA = 7;

  int n_chk = 0, n_fail = 0;
  string cur = "R12";

  int m_st[NL], m_cnt[NL], m_hsrc[NL];
  bit m_held[NL];
  bit m_ov, m_inv, m_hit, m_err;
  int m_ot, m_oa, m_od, m_ia;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic m_reset();
    for (int i = 0; i < NL; i++) begin
      m_st[i] = S_I; m_cnt[i] = 0; m_hsrc[i] = 0; m_held[i] = 0;
    end
    m_ov = 0; m_inv = 0; m_hit = 0; m_err = 0; m_ot = 0; m_oa = 0; m_od = 0; m_ia = 0;
  endtask

  function automatic bit pend(int s); return s >= S_IMAD; endfunction
  function automatic int m_drain();
    for (int i = 0; i < NL; i++) if (m_held[i] && m_st[i] == S_M) return i;
    return -1;
  endfunction
  function automatic bit m_free(); return !m_ov || net_out_ready; endfunction
  function automatic bit m_net_rdy();
    return m_free() && m_drain() < 0 && !(net_in_type == 3 && m_held[net_in_addr]);
  endfunction
  function automatic bit m_l1_rdy();
    return m_free() && m_drain() < 0 && !net_in_valid && m_st[l1_req_addr] <= S_M;
  endfunction

  task automatic m_emit(int t, int a, int d);
    m_ov = 1; m_ot = t; m_oa = a; m_od = d;
  endtask

  task automatic m_update();
    int d, a, s;
    bit fr, nr, lr;
    d = m_drain(); fr = m_free(); nr = m_net_rdy(); lr = m_l1_rdy();
    m_inv = 0; m_hit = 0; m_err = 0;
    if (m_ov && net_out_ready) m_ov = 0;
    if (d >= 0 && fr) begin
      m_emit(3, d, m_hsrc[d]); m_inv = 1; m_ia = d; m_st[d] = S_I; m_held[d] = 0;
    end else if (net_in_valid && nr) begin
      a = int'(net_in_addr); s = int'(net_in_src);
      case (int'(net_in_type))
        0: if (m_st[a] == S_ISD) m_st[a] = S_S;
           else if (m_st[a] == S_IMAD || m_st[a] == S_SMAD) begin
             m_cnt[a] += int'(net_in_acks);
             if (m_cnt[a] == 0) m_st[a] = S_M;
             else m_st[a] = (m_st[a] == S_IMAD) ? S_IMA : S_SMA;
           end else m_err = 1;
        1: if (m_st[a] == S_S || m_st[a] == S_SMAD) begin
             m_st[a] = (m_st[a] == S_S) ? S_I : S_IMAD;
             m_emit(2, a, s); m_inv = 1; m_ia = a;
           end else m_err = 1;
        2: if (pend(m_st[a])) begin
             m_cnt[a]--;
             if ((m_st[a] == S_IMA || m_st[a] == S_SMA) && m_cnt[a] == 0) m_st[a] = S_M;
           end else m_err = 1;
        default: if (m_st[a] == S_M) begin
             m_emit(3, a, s); m_inv = 1; m_ia = a; m_st[a] = S_I;
           end else if (pend(m_st[a])) begin
             m_held[a] = 1; m_hsrc[a] = s;
           end else m_err = 1;
      endcase
    end else if (l1_req_valid && lr) begin
      a = int'(l1_req_addr);
      if (m_st[a] == S_I) begin
        m_emit(l1_req_write ? 1 : 0, a, 0); m_st[a] = l1_req_write ? S_IMAD : S_ISD;
      end else if (m_st[a] == S_S && l1_req_write) begin
        m_emit(1, a, 0); m_st[a] = S_SMAD;
      end else m_hit = 1;
    end
  endtask

  task automatic cmp_regs();
    chk(cur, "net_out_valid", int'(net_out_valid), int'(m_ov));
    if (m_ov) begin
      chk(cur, "net_out_type", int'(net_out_type), m_ot);
      chk(cur, "net_out_addr", int'(net_out_addr), m_oa);
      chk(cur, "net_out_dst", int'(net_out_dst), m_od);
    end
    chk(cur, "l1_inv_valid", int'(l1_inv_valid), int'(m_inv));
    if (m_inv) chk(cur, "l1_inv_addr", int'(l1_inv_addr), m_ia);
    chk(cur, "l1_hit", int'(l1_hit), int'(m_hit));
    chk(cur, "err", int'(err), int'(m_err));
  endtask

  // inputs set at negedge; readies compared mid-low phase, registers after the edge
  task automatic cyc();
    #1;
    chk(cur, "net_in_ready", int'(net_in_ready), int'(m_net_rdy()));
    chk(cur, "l1_req_ready", int'(l1_req_ready), int'(m_l1_rdy()));
    m_update();
    @(posedge clk);
    @(negedge clk);
    cmp_regs();
  endtask

  task automatic l1(bit w, int a);
    l1_req_valid = 1; l1_req_write = w; l1_req_addr = 2'(a);
    cyc();
    l1_req_valid = 0;
  endtask

  task automatic net(int t, int a, int s, int k);
    net_in_valid = 1; net_in_type = 2'(t); net_in_addr = 2'(a);
    net_in_src = 3'(s); net_in_acks = 3'(k);
    cyc();
    net_in_valid = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic exp_out(string tag, int t, int a, int d);
    chk(tag, "out valid", int'(net_out_valid), 1);
    chk(tag, "out type", int'(net_out_type), t);
    chk(tag, "out addr", int'(net_out_addr), a);
    chk(tag, "out dst", int'(net_out_dst), d);
  endtask

  task automatic exp_quiet(string tag);
    chk(tag, "out valid", int'(net_out_valid), 0);
    chk(tag, "l1 inv", int'(l1_inv_valid), 0);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12: reset state
    cur = "R12";
    chk("R12", "out valid after reset", int'(net_out_valid), 0);
    chk("R12", "inv after reset", int'(l1_inv_valid), 0);
    chk("R12", "hit after reset", int'(l1_hit), 0);
    chk("R12", "err after reset", int'(err), 0);
    idle(1);

    // R13: read miss, fill, read hit
    cur = "R13";
    l1(0, 0); exp_out("R13", 0, 0, 0);
    net(0, 0, 0, 0);
    l1(0, 0); chk("R13", "read hit in S", int'(l1_hit), 1);

    // R1, R2, R5, R10, R6, R7: upgrade with owed acks and a parked forward
    cur = "R1";
    l1(1, 0); exp_out("R1", 1, 0, 0);
    l1_req_valid = 1; l1_req_write = 0; l1_req_addr = 0;
    #1 chk("R1", "L1 stalled on transient line", int'(l1_req_ready), 0);
    l1_req_valid = 0;
    idle(1);
    cur = "R2";
    net(0, 0, 0, 2); exp_quiet("R2");
    cur = "R5";
    net(3, 0, 5, 0); exp_quiet("R5");
    cur = "R10";
    net_in_valid = 1; net_in_type = 3; net_in_addr = 0; net_in_src = 6;
    #1 chk("R10", "second forward back-pressured", int'(net_in_ready), 0);
    net_in_valid = 0;
    idle(1);
    cur = "R6";
    net(2, 0, 1, 0); exp_quiet("R6");
    net(2, 0, 2, 0); exp_quiet("R6");
    idle(1);
    exp_out("R6", 3, 0, 5);
    chk("R7", "L1 invalidate on served forward", int'(l1_inv_valid), 1);
    cur = "R7";
    l1(0, 0); exp_out("R7", 0, 0, 0);
    net(0, 0, 0, 0);

    // R3, R4, R8: invalidate races the upgrade
    cur = "R3";
    l1(0, 1); net(0, 1, 0, 0);
    l1(1, 1); exp_out("R3", 1, 1, 0);
    net(1, 1, 3, 0); exp_out("R3", 2, 1, 3);
    chk("R4", "L1 invalidate in SMAD", int'(l1_inv_valid), 1);
    chk("R4", "L1 invalidate addr", int'(l1_inv_addr), 1);
    cur = "R8";
    net(0, 1, 0, 0); exp_quiet("R8");
    l1(1, 1); chk("R8", "write hit after IMAD data", int'(l1_hit), 1);
    cur = "R7";
    net(3, 1, 2, 0); exp_out("R7", 3, 1, 2);
    chk("R7", "inv on forward in M", int'(l1_inv_valid), 1);

    // R4: invalidate in Shared
    cur = "R4";
    l1(0, 3); net(0, 3, 0, 0);
    net(1, 3, 4, 0); exp_out("R4", 2, 3, 4);
    chk("R4", "inv pulse from S", int'(l1_inv_valid), 1);

    // R9: early ack before data
    cur = "R9";
    l1(1, 2); exp_out("R9", 1, 2, 0);
    net(2, 2, 1, 0); chk("R9", "early ack legal", int'(err), 0);
    net(0, 2, 0, 1);
    l1(1, 2); chk("R9", "M after ack+data", int'(l1_hit), 1);

    // R11: illegal messages leave state
    cur = "R11";
    net(2, 3, 0, 0); chk("R11", "err on ack in I", int'(err), 1);
    l1(0, 3); exp_out("R11", 0, 3, 0);
    net(0, 3, 0, 0);
    net(0, 3, 0, 0); chk("R11", "err on data in S", int'(err), 1);
    net(1, 3, 7, 0); exp_out("R11", 2, 3, 7);
    net(3, 3, 1, 0); chk("R11", "err on forward in I", int'(err), 1);

    // R14: stalled output and arbitration
    cur = "R14";
    net_out_ready = 0;
    l1(0, 3); exp_out("R14", 0, 3, 0);
    idle(2); exp_out("R14", 0, 3, 0);
    net_out_ready = 1;
    l1_req_valid = 1; l1_req_write = 1; l1_req_addr = 2;
    net_in_valid = 1; net_in_type = 0; net_in_addr = 3; net_in_src = 0; net_in_acks = 0;
    #1 chk("R14", "L1 yields to network", int'(l1_req_ready), 0);
    cyc();
    net_in_valid = 0;
    cyc();
    l1_req_valid = 0;
    chk("R14", "L1 hit after network", int'(l1_hit), 1);
    idle(2);

    // R12: reset mid-run
    cur = "R12";
    @(negedge clk);
    rst_n = 0; m_reset();
    #1;
    chk("R12", "out cleared", int'(net_out_valid), 0);
    @(negedge clk);
    rst_n = 1;
    l1(1, 2); exp_out("R12", 1, 2, 0);
    idle(2);

    summary();
    $finish;
  end

endmodule